// File: doc/BRIEF.md
# SECDED 72/64 Error-Correcting Codec

This block protects a 64-bit data word with 8 check bits. The encoder path is purely combinational. It produces the check byte for the word on its input, so a memory write path can store data and check bits side by side.

The decoder path takes a received 72-bit codeword and recomputes the check byte from the received data. It XORs that result with the received check byte to form a syndrome, then classifies the syndrome. The outcome is registered once and qualified by a valid bit.

Every data bit owns a fixed odd-weight 8-bit column, and these columns are not a generated Hamming layout. For that reason:
- a single data-bit error produces a syndrome equal to that bit's column, and the decoder corrects it;
- a single check-bit error produces a one-hot syndrome, and the decoder reports it as a correctable error in the check field without touching the data;
- any other nonzero syndrome, including every even-weight one, is reported as uncorrectable.

Top module: `secded_codec`

## Requirements
- R1: Encoder check bit j is the XOR of every data bit whose column has bit j set. The columns for data bits 0..63 are, in ascending bit order:
  - F4 F1 EC EA E9 E6 E5 E3
  - DC DA D9 D6 D5 D3 CE CB
  - B5 B0 AD AB A8 A7 A4 A2
  - 9D 9B 98 97 94 92 8F 8A
  - 75 70 6D 6B 68 67 64 62
  - 5E 5B 58 57 54 52 4F 4A
  - 34 31 2C 2A 29 26 25 23
  - 1C 1A 19 16 15 13 0E 0B

  For example, a word with only bit 0 set encodes to 0xF4, and a word with only bit 63 set encodes to 0x0B.
- R2: The decoder has exactly one register stage. `dec_valid_o` equals `dec_valid_i` of the previous cycle, and all decoder outputs describe the codeword presented in that previous cycle.
- R3: `dec_syndrome_o` equals the received check byte XOR the check byte that R1 computes from the received data.
- R4: A zero syndrome raises neither flag, passes the data unchanged, and drives `dec_err_idx_o` = 0 and `dec_err_in_check_o` = 0.
- R5: A syndrome equal to the column of data bit i inverts data bit i, raises `dec_ce_o`, drives `dec_err_idx_o` = i and keeps `dec_err_in_check_o` = 0.
- R6: A syndrome equal to 1<<j (j = 0..7) raises `dec_ce_o` and `dec_err_in_check_o`, drives `dec_err_idx_o` = j, and passes the data unchanged.
- R7: Every other nonzero syndrome (for example 0x03, or any double flip) raises `dec_ue_o`, keeps `dec_ce_o` low, passes the data unchanged and drives `dec_err_idx_o` = 0.
- R8: `dec_ce_o` and `dec_ue_o` are never high together.
- R9: While `rst_n` is low, and in the first cycle after it, `dec_valid_o`, `dec_ce_o` and `dec_ue_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_data_i | input | 64 | Data word to encode |
| enc_check_o | output | 8 | Check byte for `enc_data_i` (combinational) |
| dec_valid_i | input | 1 | Codeword on the decoder inputs is valid |
| dec_data_i | input | 64 | Received data field |
| dec_check_i | input | 8 | Received check field |
| dec_valid_o | output | 1 | Decoder result valid |
| dec_data_o | output | 64 | Corrected (or passed-through) data |
| dec_syndrome_o | output | 8 | Syndrome of the decoded codeword |
| dec_ce_o | output | 1 | Correctable single-bit error seen |
| dec_ue_o | output | 1 | Uncorrectable error seen |
| dec_err_in_check_o | output | 1 | The corrected bit lies in the check field |
| dec_err_idx_o | output | 6 | Index of the flipped bit (data 0..63 or check 0..7) |

## Verification
The cycle-level properties cover the following on every cycle:
- the one-cycle valid latency;
- mutual exclusion of the two flags;
- a clean syndrome giving untouched data;
- a one-hot syndrome being reported as a check-field error with untouched data;
- every even-weight nonzero syndrome becoming uncorrectable with pass-through data;
- a data correction changing exactly one bit.

The properties cannot tell whether the matrix columns themselves are right, or whether the reported index names the bit that was actually flipped. Those two facts rest on the bench's scenarios: walking single flips across all 72 positions, hand-picked encoder words, the 0x03 check-pair case, and random double flips, each compared with an independent model.

// File: rtl/secded_pkg.sv
package secded_pkg;

    localparam int DATA_W = 64;
    localparam int CHK_W  = 8;
    localparam int IDX_W  = $clog2(DATA_W);

    // Parity-check columns, data bit 63 in the most significant byte.
    localparam logic [DATA_W*CHK_W-1:0] COLUMNS = {
        8'h0B, 8'h0E, 8'h13, 8'h15, 8'h16, 8'h19, 8'h1A, 8'h1C,
        8'h23, 8'h25, 8'h26, 8'h29, 8'h2A, 8'h2C, 8'h31, 8'h34,
        8'h4A, 8'h4F, 8'h52, 8'h54, 8'h57, 8'h58, 8'h5B, 8'h5E,
        8'h62, 8'h64, 8'h67, 8'h68, 8'h6B, 8'h6D, 8'h70, 8'h75,
        8'h8A, 8'h8F, 8'h92, 8'h94, 8'h97, 8'h98, 8'h9B, 8'h9D,
        8'hA2, 8'hA4, 8'hA7, 8'hA8, 8'hAB, 8'hAD, 8'hB0, 8'hB5,
        8'hCB, 8'hCE, 8'hD3, 8'hD5, 8'hD6, 8'hD9, 8'hDA, 8'hDC,
        8'hE3, 8'hE5, 8'hE6, 8'hE9, 8'hEA, 8'hEC, 8'hF1, 8'hF4
    };

    // Data bits that feed check bit j.
    function automatic logic [DATA_W-1:0] row_mask(input int j);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < DATA_W; i++) begin
            m[i] = COLUMNS[i*CHK_W + j];
        end
        return m;
    endfunction

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
        logic [CHK_W-1:0]  synd;
        logic              ce;
        logic              ue;
        logic              in_chk;
        logic [IDX_W-1:0]  idx;
    } dec_out_t;

endpackage

// File: rtl/secded_chkgen.sv
module secded_chkgen
    import secded_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = CHK_W
) (
    input  logic [DW-1:0] data_i,
    output logic [CW-1:0] chk_o
);

    for (genvar j = 0; j < CW; j++) begin : g_row
        localparam logic [DW-1:0] MASK = row_mask(j);
        assign chk_o[j] = ^(data_i & MASK);
    end

endmodule

// File: rtl/secded_classify.sv
module secded_classify
    import secded_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = CHK_W,
    parameter int IW = IDX_W
) (
    input  logic [CW-1:0] synd_i,
    output logic          data_hit_o,
    output logic [DW-1:0] flip_o,
    output logic [IW-1:0] data_idx_o,
    output logic          chk_hit_o,
    output logic [IW-1:0] chk_idx_o
);

    for (genvar g = 0; g < DW; g++) begin : g_col
        assign flip_o[g] = (synd_i == COLUMNS[g*CW +: CW]);
    end

    assign data_hit_o = |flip_o;
    assign chk_hit_o  = ($countones(synd_i) == 1);

    always_comb begin
        data_idx_o = '0;
        for (int i = 0; i < DW; i++) begin
            if (flip_o[i]) begin
                data_idx_o = data_idx_o | IW'(i);
            end
        end
    end

    always_comb begin
        chk_idx_o = '0;
        for (int j = 0; j < CW; j++) begin
            if (synd_i[j]) begin
                chk_idx_o = chk_idx_o | IW'(j);
            end
        end
    end

endmodule

// File: rtl/secded_codec.sv
module secded_codec
    import secded_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] enc_data_i,
    output logic [CHK_W-1:0]  enc_check_o,
    input  logic              dec_valid_i,
    input  logic [DATA_W-1:0] dec_data_i,
    input  logic [CHK_W-1:0]  dec_check_i,
    output logic              dec_valid_o,
    output logic [DATA_W-1:0] dec_data_o,
    output logic [CHK_W-1:0]  dec_syndrome_o,
    output logic              dec_ce_o,
    output logic              dec_ue_o,
    output logic              dec_err_in_check_o,
    output logic [IDX_W-1:0]  dec_err_idx_o
);

    logic [CHK_W-1:0]  recalc;
    logic [CHK_W-1:0]  synd;
    logic              data_hit;
    logic [DATA_W-1:0] flip;
    logic [IDX_W-1:0]  data_idx;
    logic              chk_hit;
    logic [IDX_W-1:0]  chk_idx;
    dec_out_t          out_d, out_q;

    secded_chkgen #(.DW(DATA_W), .CW(CHK_W)) u_enc (
        .data_i (enc_data_i),
        .chk_o  (enc_check_o)
    );

    secded_chkgen #(.DW(DATA_W), .CW(CHK_W)) u_recalc (
        .data_i (dec_data_i),
        .chk_o  (recalc)
    );

    assign synd = dec_check_i ^ recalc;

    secded_classify #(.DW(DATA_W), .CW(CHK_W), .IW(IDX_W)) u_cls (
        .synd_i     (synd),
        .data_hit_o (data_hit),
        .flip_o     (flip),
        .data_idx_o (data_idx),
        .chk_hit_o  (chk_hit),
        .chk_idx_o  (chk_idx)
    );

    always_comb begin
        out_d        = '0;
        out_d.valid  = dec_valid_i;
        out_d.synd   = synd;
        out_d.data   = dec_data_i;
        if (synd == '0) begin
            out_d.ce = 1'b0;
        end else if (data_hit) begin
            out_d.data = dec_data_i ^ flip;
            out_d.ce   = 1'b1;
            out_d.idx  = data_idx;
        end else if (chk_hit) begin
            out_d.ce     = 1'b1;
            out_d.in_chk = 1'b1;
            out_d.idx    = chk_idx;
        end else begin
            out_d.ue = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign dec_valid_o        = out_q.valid;
    assign dec_data_o         = out_q.data;
    assign dec_syndrome_o     = out_q.synd;
    assign dec_ce_o           = out_q.ce;
    assign dec_ue_o           = out_q.ue;
    assign dec_err_in_check_o = out_q.in_chk;
    assign dec_err_idx_o      = out_q.idx;

endmodule

// File: rtl/secded_codec_chk.sv
module secded_codec_chk
    import secded_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              dec_valid_i,
    input logic [DATA_W-1:0] dec_data_i,
    input logic              dec_valid_o,
    input logic [DATA_W-1:0] dec_data_o,
    input logic [CHK_W-1:0]  dec_syndrome_o,
    input logic              dec_ce_o,
    input logic              dec_ue_o,
    input logic              dec_err_in_check_o
);

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid_i |=> dec_valid_o);

    a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid_i |=> !dec_valid_o);

    a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(dec_ce_o && dec_ue_o));

    a_r4_clean_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid_o && dec_syndrome_o == '0) |->
            (!dec_ce_o && !dec_ue_o && dec_data_o == $past(dec_data_i)));

    a_r6_check_single: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid_o && $countones(dec_syndrome_o) == 1) |->
            (dec_ce_o && dec_err_in_check_o && dec_data_o == $past(dec_data_i)));

    a_r7_even_uncorrectable: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid_o && dec_syndrome_o != '0 && !(^dec_syndrome_o)) |->
            (dec_ue_o && dec_data_o == $past(dec_data_i)));

    a_r5_one_bit_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid_o && dec_ce_o && !dec_err_in_check_o) |->
            ($countones(dec_data_o ^ $past(dec_data_i)) == 1));

endmodule

bind secded_codec secded_codec_chk u_chk (
    .clk                (clk),
    .rst_n              (rst_n),
    .dec_valid_i        (dec_valid_i),
    .dec_data_i         (dec_data_i),
    .dec_valid_o        (dec_valid_o),
    .dec_data_o         (dec_data_o),
    .dec_syndrome_o     (dec_syndrome_o),
    .dec_ce_o           (dec_ce_o),
    .dec_ue_o           (dec_ue_o),
    .dec_err_in_check_o (dec_err_in_check_o)
);

// File: tb/secded_codec_bench.sv
module secded_codec_bench;

    localparam logic [511:0] TB_COLS = {
        8'h0B, 8'h0E, 8'h13, 8'h15, 8'h16, 8'h19, 8'h1A, 8'h1C,
        8'h23, 8'h25, 8'h26, 8'h29, 8'h2A, 8'h2C, 8'h31, 8'h34,
        8'h4A, 8'h4F, 8'h52, 8'h54, 8'h57, 8'h58, 8'h5B, 8'h5E,
        8'h62, 8'h64, 8'h67, 8'h68, 8'h6B, 8'h6D, 8'h70, 8'h75,
        8'h8A, 8'h8F, 8'h92, 8'h94, 8'h97, 8'h98, 8'h9B, 8'h9D,
        8'hA2, 8'hA4, 8'hA7, 8'hA8, 8'hAB, 8'hAD, 8'hB0, 8'hB5,
        8'hCB, 8'hCE, 8'hD3, 8'hD5, 8'hD6, 8'hD9, 8'hDA, 8'hDC,
        8'hE3, 8'hE5, 8'hE6, 8'hE9, 8'hEA, 8'hEC, 8'hF1, 8'hF4
    };

    typedef struct {
        logic [63:0] data;
        logic [7:0]  synd;
        logic        ce;
        logic        ue;
        logic        in_chk;
        logic [5:0]  idx;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] enc_data_i = '0;
    logic [7:0]  enc_check_o;
    logic        dec_valid_i = 1'b0;
    logic [63:0] dec_data_i = '0;
    logic [7:0]  dec_check_i = '0;
    logic        dec_valid_o;
    logic [63:0] dec_data_o;
    logic [7:0]  dec_syndrome_o;
    logic        dec_ce_o;
    logic        dec_ue_o;
    logic        dec_err_in_check_o;
    logic [5:0]  dec_err_idx_o;

    int   n_run = 0;
    int   n_fail = 0;
    exp_t sb[$];

    always #5 clk = ~clk;

    secded_codec u_secded_codec (
        .clk                (clk),
        .rst_n              (rst_n),
        .enc_data_i         (enc_data_i),
        .enc_check_o        (enc_check_o),
        .dec_valid_i        (dec_valid_i),
        .dec_data_i         (dec_data_i),
        .dec_check_i        (dec_check_i),
        .dec_valid_o        (dec_valid_o),
        .dec_data_o         (dec_data_o),
        .dec_syndrome_o     (dec_syndrome_o),
        .dec_ce_o           (dec_ce_o),
        .dec_ue_o           (dec_ue_o),
        .dec_err_in_check_o (dec_err_in_check_o),
        .dec_err_idx_o      (dec_err_idx_o)
    );

    function automatic logic [7:0] model_enc(input logic [63:0] d);
        logic [7:0] c;
        c = '0;
        for (int i = 0; i < 64; i++) begin
            if (d[i]) c = c ^ TB_COLS[i*8 +: 8];
        end
        return c;
    endfunction

    function automatic exp_t model_dec(input logic [63:0] d, input logic [7:0] c, input string req);
        exp_t e;
        e.data = d; e.synd = c ^ model_enc(d);
        e.ce = 1'b0; e.ue = 1'b0; e.in_chk = 1'b0; e.idx = '0; e.req = req;
        if (e.synd != 8'h00) begin
            for (int i = 0; i < 64; i++) begin
                if (e.synd == TB_COLS[i*8 +: 8]) begin
                    e.data[i] = ~d[i]; e.ce = 1'b1; e.idx = 6'(i);
                end
            end
            for (int j = 0; j < 8; j++) begin
                if (e.synd == (8'h01 << j)) begin
                    e.ce = 1'b1; e.in_chk = 1'b1; e.idx = 6'(j);
                end
            end
            if (!e.ce) e.ue = 1'b1;
        end
        return e;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [63:0] d, input logic [7:0] c, input string req);
        @(negedge clk);
        dec_valid_i = 1'b1;
        dec_data_i  = d;
        dec_check_i = c;
        sb.push_back(model_dec(d, c, req));
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            dec_valid_i = 1'b0;
        end
    endtask

    task automatic enc_check(input logic [63:0] d, input logic [7:0] exp, input string req);
        enc_data_i = d;
        #1;
        check(enc_check_o == exp, req, "encoder", 64'(enc_check_o), 64'(exp));
    endtask

    // Monitor: pops expected results as the decoder presents them.
    always begin
        @(posedge clk);
        #2;
        if (rst_n && dec_valid_o) begin
            check(!(dec_ce_o && dec_ue_o), "R8", "both flags", {dec_ce_o, dec_ue_o}, 0);
            if (sb.size() == 0) begin
                check(1'b0, "R2", "unexpected valid", 64'(dec_valid_o), 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(dec_syndrome_o == e.synd, "R3", {e.req, " syndrome"},
                      64'(dec_syndrome_o), 64'(e.synd));
                check(dec_data_o == e.data && dec_ce_o == e.ce && dec_ue_o == e.ue &&
                      dec_err_in_check_o == e.in_chk && dec_err_idx_o == e.idx,
                      e.req, "data/flags/idx",
                      {dec_data_o[47:0], 4'(dec_ce_o), 4'(dec_ue_o), 2'(dec_err_in_check_o), dec_err_idx_o},
                      {e.data[47:0], 4'(e.ce), 4'(e.ue), 2'(e.in_chk), e.idx});
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] d;
        logic [7:0]  c;
        void'($urandom(32'h5EC0DED));

        // R9: reset state
        repeat (3) @(posedge clk);
        #2;
        check(!dec_valid_o && !dec_ce_o && !dec_ue_o, "R9", "reset state",
              {dec_valid_o, dec_ce_o, dec_ue_o}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #2;
        check(!dec_valid_o && !dec_ce_o && !dec_ue_o, "R9", "first cycle",
              {dec_valid_o, dec_ce_o, dec_ue_o}, 0);

        // R1: encoder
        enc_check(64'h1, 8'hF4, "R1");
        enc_check(64'h8000_0000_0000_0000, 8'h0B, "R1");
        enc_check(64'h0000_0001_0000_0000, 8'h75, "R1");
        enc_check(64'h0, 8'h00, "R1");
        enc_check(64'h3, 8'hF4 ^ 8'hF1, "R1");
        for (int k = 0; k < 8; k++) begin
            d = {$urandom, $urandom};
            enc_check(d, model_enc(d), "R1");
        end

        // R4/R2: clean codewords, back to back then with gaps
        send(64'h0, 8'h00, "R4");
        send(64'hFFFF_FFFF_FFFF_FFFF, model_enc(64'hFFFF_FFFF_FFFF_FFFF), "R4");
        for (int k = 0; k < 6; k++) begin
            d = {$urandom, $urandom};
            send(d, model_enc(d), "R4");
        end
        idle(1);
        @(posedge clk);
        #2;
        check(!dec_valid_o, "R2", "idle gap", 64'(dec_valid_o), 0);

        // R5: every single data flip
        for (int i = 0; i < 64; i++) begin
            d = {$urandom, $urandom};
            c = model_enc(d);
            send(d ^ (64'h1 << i), c, "R5");
        end

        // R6: every single check flip
        for (int j = 0; j < 8; j++) begin
            d = {$urandom, $urandom};
            send(d, model_enc(d) ^ (8'h01 << j), "R6");
        end

        // R7: check pair 0 and 1 (syndrome 0x03), then random double flips
        d = 64'h0123_4567_89AB_CDEF;
        send(d, model_enc(d) ^ 8'h03, "R7");
        for (int k = 0; k < 60; k++) begin
            int a;
            int b;
            logic [71:0] cw;
            d  = {$urandom, $urandom};
            cw = {model_enc(d), d};
            a  = $urandom_range(71, 0);
            b  = (a + 1 + $urandom_range(70, 0)) % 72;
            cw[a] = ~cw[a];
            cw[b] = ~cw[b];
            send(cw[63:0], cw[71:64], "R7");
        end

        idle(3);
        repeat (2) @(posedge clk);
        check(sb.size() == 0, "R2", "drained", 64'(sb.size()), 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule